// File: doc/BRIEF.md
# DRAM Access Strobe Sequencer

This block sits between a processor's memory request and a bank of dynamic RAM. It takes a row address, a column address and a bank number, holds them in address latches and turns one access request into the DRAM strobe sequence. The bank number selects one of four row-strobe outputs. The shared address bus first carries the row address, then switches to the column address, and the column strobe follows.

When the access begins, the selected row strobe turns on at the next clock edge. In automatic timing the column strobe follows a fixed number of cycles later. In external timing the column strobe comes from a separate request input once the column address is on the bus. After the first column strobe, toggling that input produces page or nibble follow-on cycles within the same open row. The column latch can be reopened between them to present a new column. Dropping the access request closes the row. A busy input, driven by a refresh arbiter, stops new accesses from starting. The write enable is passed through to the DRAMs on a register.

All strobe outputs are active-high at this boundary. A pad stage inverts them where the DRAMs need active-low levels.

Top module: `dram_access_seq`

## Requirements
- R1: While `adr_stb` is 1 the row, column and bank inputs pass straight through the latches. While it is 0 the latches hold the values present at the last cycle it was 1. When idle, `mux_addr` shows the latched row one cycle after the latch output changes.
- R2: If `acc_req` is 1 while idle and `busy` is 0, then at the next edge the strobe `ras_out[b]` becomes 1, where b is the latched bank number, and `mux_addr` carries the latched row.
- R3: No more than one bit of `ras_out` is ever 1, and that bit keeps its position until the access ends.
- R4: In automatic timing (`ext_cas` = 0 at the start), `mux_addr` switches to the latched column HOLD_CYC edges after `ras_out` is set. `cas_out` becomes 1 one edge after that switch and stays 1 until `cas_req` has been seen at 1.
- R5: In external timing (`ext_cas` = 1 at the start), the address switch happens at the same edge as in R4. `cas_out` stays 0 until that switch, then copies `cas_req` with one cycle of delay.
- R6: After the first column strobe, `cas_out` follows `cas_req` with one cycle of delay, which gives page and nibble cycles. A column reloaded through the latch appears on `mux_addr` one cycle later, while the row strobe stays on.
- R7: When `acc_req` is 0 during an access, the next edge clears `ras_out` and `cas_out` and puts the latched row back on `mux_addr`.
- R8: While `busy` is 1 and the block is idle, `acc_req` starts no access and `ras_out` stays 0.
- R9: `we_out` equals `we_in` delayed by one clock.
- R10: Synchronous reset clears `ras_out`, `cas_out`, `we_out` and `mux_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_stb | input | 1 | Address latch enable: 1 passes the inputs through, 0 holds them |
| row_in | input | 9 | Row address |
| col_in | input | 9 | Column address |
| bank_in | input | 2 | Bank number |
| acc_req | input | 1 | Access request; keeps the row open while 1 |
| cas_req | input | 1 | Column strobe request for external timing and page cycles |
| ext_cas | input | 1 | 1 selects external column timing, sampled at access start |
| busy | input | 1 | Blocks the start of a new access |
| we_in | input | 1 | Write enable from the host |
| mux_addr | output | 9 | Multiplexed row/column address |
| ras_out | output | 4 | Row strobes, one per bank, active-high |
| cas_out | output | 1 | Column strobe, active-high |
| we_out | output | 1 | Write enable to the DRAMs |

## Verification
Several rules are checked on every cycle: at most one row strobe is on, the column strobe only appears while a row is open and the sequencer is in a column phase, a dropped request closes the access at the next edge, and busy keeps the sequencer idle. The exact cycle of the row-to-column switch and of the first column strobe, the latch hold and transparency, page cycles with a reloaded column, and the write-enable delay can only be shown by the bench. The bench sweeps every bank in both timing modes with computed addresses.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int ADDR_W  = 9;
  localparam int BANK_W  = 2;
  localparam int BANKS   = 1 << BANK_W;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ROW  = 3'd1,
    SQ_COLW = 3'd2,
    SQ_AUTO = 3'd3,
    SQ_PAGE = 3'd4
  } sq_state_t;

  function automatic logic is_col_phase(input sq_state_t s);
    return (s == SQ_COLW) || (s == SQ_AUTO) || (s == SQ_PAGE);
  endfunction
endpackage

// File: rtl/dseq_addr_latch.sv
module dseq_addr_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (open_i) held_q <= d_i;
  end

  // transparent while open, holding the last open value otherwise
  assign q_o = open_i ? d_i : held_q;
endmodule

// File: rtl/dseq_bank_decode.sv
module dseq_bank_decode #(
  parameter int SEL_W = 2,
  localparam int N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hot_o[i] = (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
  import dseq_pkg::*;
#(
  parameter int HOLD_CYC = 1,
  localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_req_i,
  input  logic cas_req_i,
  input  logic ext_cas_i,
  input  logic busy_i,
  output logic start_o,
  output logic stop_o,
  output logic col_next_o,
  output logic cas_o
);
  sq_state_t  st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic       ext_q;
  logic       cas_d;

  assign start_o = (st_q == SQ_IDLE) && acc_req_i && !busy_i;
  assign stop_o  = (st_q != SQ_IDLE) && !acc_req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (start_o) st_d = SQ_ROW;
      SQ_ROW: begin
        if (!acc_req_i)                          st_d = SQ_IDLE;
        else if (cnt_q == CNT_W'(HOLD_CYC - 1))  st_d = ext_q ? SQ_PAGE : SQ_COLW;
      end
      SQ_COLW: st_d = acc_req_i ? SQ_AUTO : SQ_IDLE;
      SQ_AUTO: begin
        if (!acc_req_i)     st_d = SQ_IDLE;
        else if (cas_req_i) st_d = SQ_PAGE;
      end
      SQ_PAGE: if (!acc_req_i) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    cas_d = 1'b0;
    if (acc_req_i) begin
      unique case (st_q)
        SQ_COLW, SQ_AUTO: cas_d = 1'b1;
        SQ_PAGE:          cas_d = cas_req_i;
        default:          cas_d = 1'b0;
      endcase
    end
  end

  assign col_next_o = is_col_phase(st_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      ext_q <= 1'b0;
      cas_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      cas_o <= cas_d;
      if (start_o) begin
        cnt_q <= '0;
        ext_q <= ext_cas_i;
      end else if (st_q == SQ_ROW) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CAS_IN_COL_PHASE: assert property (@(posedge clk) disable iff (rst)
    cas_o |-> (st_q == SQ_AUTO || st_q == SQ_PAGE)); // R5
  AST_DROP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> (st_q == SQ_IDLE && !cas_o)); // R7
  AST_BUSY_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_IDLE && busy_i) |=> (st_q == SQ_IDLE)); // R8
endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dseq_pkg::*;
#(
  parameter int HOLD_CYC = 1,
  parameter int AW = ADDR_W,
  parameter int BW = BANK_W,
  localparam int NB = 1 << BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adr_stb,
  input  logic [AW-1:0] row_in,
  input  logic [AW-1:0] col_in,
  input  logic [BW-1:0] bank_in,
  input  logic          acc_req,
  input  logic          cas_req,
  input  logic          ext_cas,
  input  logic          busy,
  input  logic          we_in,
  output logic [AW-1:0] mux_addr,
  output logic [NB-1:0] ras_out,
  output logic          cas_out,
  output logic          we_out
);
  logic [AW-1:0] row_l, col_l;
  logic [BW-1:0] bank_l;
  logic [NB-1:0] bank_hot;
  logic          start, stop, col_next;

  dseq_addr_latch #(.W(AW)) u_row  (.clk(clk), .rst(rst), .open_i(adr_stb), .d_i(row_in),  .q_o(row_l));
  dseq_addr_latch #(.W(AW)) u_col  (.clk(clk), .rst(rst), .open_i(adr_stb), .d_i(col_in),  .q_o(col_l));
  dseq_addr_latch #(.W(BW)) u_bank (.clk(clk), .rst(rst), .open_i(adr_stb), .d_i(bank_in), .q_o(bank_l));

  dseq_bank_decode #(.SEL_W(BW)) u_dec (.sel_i(bank_l), .hot_o(bank_hot));

  dseq_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk(clk), .rst(rst), .acc_req_i(acc_req), .cas_req_i(cas_req),
    .ext_cas_i(ext_cas), .busy_i(busy), .start_o(start), .stop_o(stop),
    .col_next_o(col_next), .cas_o(cas_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_out  <= '0;
      mux_addr <= '0;
      we_out   <= 1'b0;
    end else begin
      we_out   <= we_in;
      mux_addr <= col_next ? col_l : row_l;
      if (start)     ras_out <= bank_hot;
      else if (stop) ras_out <= '0;
    end
  end

  AST_RAS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ras_out)); // R3
  AST_RAS_STEADY: assert property (@(posedge clk) disable iff (rst)
    (ras_out != '0 && acc_req) |=> (ras_out == $past(ras_out))); // R3
  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
    cas_out |-> (ras_out != '0)); // R4
endmodule

// File: tb/tb_dram_access_seq.sv
module tb_dram_access_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adr_stb = 1'b0;
  logic [8:0] row_in = '0, col_in = '0;
  logic [1:0] bank_in = '0;
  logic       acc_req = 1'b0, cas_req = 1'b0, ext_cas = 1'b0, busy = 1'b0, we_in = 1'b0;
  logic [8:0] mux_addr;
  logic [3:0] ras_out;
  logic       cas_out, we_out;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dram_access_seq #(.HOLD_CYC(1)) dut (
    .clk(clk), .rst(rst), .adr_stb(adr_stb), .row_in(row_in), .col_in(col_in),
    .bank_in(bank_in), .acc_req(acc_req), .cas_req(cas_req), .ext_cas(ext_cas),
    .busy(busy), .we_in(we_in), .mux_addr(mux_addr), .ras_out(ras_out),
    .cas_out(cas_out), .we_out(we_out)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input bit ext, input int bank, input int row, input int col, input int col2);
    adr_stb = 1; row_in = 9'(row); col_in = 9'(col); bank_in = 2'(bank);
    tick();
    tick();
    chk("R1 idle row through latch", mux_addr, row);
    adr_stb = 0; row_in = ~9'(row); col_in = ~9'(col); bank_in = ~2'(bank);
    ext_cas = ext; cas_req = ext; acc_req = 1;
    tick();
    chk("R2 bank strobe", ras_out, 1 << bank);
    chk("R1 row held", mux_addr, row);
    chk("R2 no cas yet", cas_out, 0);
    tick();
    chk("R4 column switch", mux_addr, col);
    chk("R5 cas before switch", cas_out, 0);
    tick();
    chk(ext ? "R5 external cas" : "R4 auto cas", cas_out, 1);
    cas_req = 1; tick();
    chk("R6 cas held", cas_out, 1);
    cas_req = 0; tick();
    chk("R6 page cas low", cas_out, 0);
    adr_stb = 1; row_in = 9'(row); col_in = 9'(col2); bank_in = 2'(bank);
    tick();
    chk("R6 new column", mux_addr, col2);
    cas_req = 1; tick();
    chk("R6 page cas high", cas_out, 1);
    chk("R3 strobe kept", ras_out, 1 << bank);
    adr_stb = 0; acc_req = 0; cas_req = 0;
    tick();
    chk("R7 ras closed", ras_out, 0);
    chk("R7 cas closed", cas_out, 0);
    chk("R7 row back", mux_addr, row);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R10 ras reset", ras_out, 0);
    chk("R10 cas reset", cas_out, 0);
    chk("R10 we reset", we_out, 0);
    chk("R10 addr reset", mux_addr, 0);
    rst = 0;
    tick();
    for (int w = 0; w < 4; w++) begin
      we_in = w[0]; tick();
      chk("R9 write enable", we_out, w & 1);
    end
    adr_stb = 1; row_in = 9'd300; bank_in = 2'd2; busy = 1; acc_req = 1;
    tick(); adr_stb = 0; tick();
    chk("R8 busy blocks", ras_out, 0);
    tick();
    chk("R8 busy still blocks", ras_out, 0);
    busy = 0; tick();
    chk("R8 start after busy", ras_out, 4);
    acc_req = 0; tick();
    chk("R7 close", ras_out, 0);
    for (int e = 0; e < 2; e++)
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 3; k++)
          access(e[0], b, (b * 73 + e * 151 + k * 37) % 512,
                 (b * 29 + e * 97 + k * 211 + 5) % 512,
                 (b * 131 + k * 59 + 400) % 512);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule